// File: doc/BRIEF.md
# Debug Arm and Breakpoint Controller

This block holds the control register of an on-chip debug unit and converts its settings into sequencer commands and breakpoint requests. Software writes one 8-bit control word. The word arms the unit, asks for an immediate trigger, enables the passing of coprocessor software breaks, selects how main-CPU breaks are delivered, picks which processors a sequencer break halts, and selects the comparator bank that is visible.

Once armed, the register locks. Only the arm and trigger bits can then change. The controller sends a pulse into the external state sequencer when arming starts a session, and another when a trigger forces it to its final state. When the session ends, it raises breakpoint pulses towards the main CPU and the coprocessor. The session ends when the final state is reached with tracing off, or when the trace finishes with tracing on. The main-CPU break is steered to background debug or to a software interrupt.

Top module: `dbg_arm_ctrl`

## Requirements
- R1: Control word layout: bit0 arm, bit1 trigger, bit2 coprocessor-break enable, bit3 break mode, bits5:4 target, bits7:6 bank. `rd_data` returns this word with bit1 always 0. Software may set or clear arm. Hardware clears arm when `trace_done` arrives while armed with `trace_en` high. Hardware also clears arm when `final_reached` arrives while armed with `trace_en` low and a nonzero target. A hardware clear wins over a write in the same cycle.
- R2: A write that sets arm while the unit is disarmed raises `seq_enter_first` for exactly the one cycle in which `rd_data[0]` first reads 1.
- R3: While armed, a write changes only arm (and may request a trigger). `rd_data[7:2]` keeps its value.
- R4: A write made while armed, with bits 1 and 0 both set, raises `seq_force_final` for one cycle after the write edge. A write with bit1 clear never raises it, and bit1 reads back as 0.
- R5: A trigger write has no effect while `secure` is high or `trace_started` is high.
- R6: Target encoding: 00 halts nothing, 01 raises `cp_brk`, 10 raises a main-CPU break, 11 raises both.
- R7: With `trace_en` low, the session break is registered on the edge that samples `final_reached` while armed. With `trace_en` high, `final_reached` raises no break, and the break follows `trace_done` instead.
- R8: A `cp_swbrk_req` raises a main-CPU break on the next edge when bit2 is set, whatever the target or arm state. It is blocked when bit2 is clear.
- R9: A main-CPU break goes to `brk_bgnd` when the mode bit and `bgnd_en` are both 1. It goes to `brk_swi` when `bgnd_en` is 0. It is dropped when the mode bit is 0 and `bgnd_en` is 1.
- R10: `bank_oh` is the one-hot decode of bits7:6 (bank 0 = 0001). Reset clears the whole word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write data |
| rd_data | output | 8 | Control word readback |
| trace_en | input | 1 | Tracing is enabled for this session |
| trace_started | input | 1 | Trace capture already running with begin or mid alignment |
| trace_done | input | 1 | Tracing session complete |
| final_reached | input | 1 | Sequencer has reached its final state |
| secure | input | 1 | Secure mode, trigger writes ignored |
| bgnd_en | input | 1 | Background debug is available |
| cp_swbrk_req | input | 1 | Coprocessor software break request |
| seq_enter_first | output | 1 | Pulse: sequencer enters its first state |
| seq_force_final | output | 1 | Pulse: sequencer jumps to its final state |
| cp_brk | output | 1 | Pulse: breakpoint to the coprocessor |
| brk_bgnd | output | 1 | Pulse: main-CPU break into background debug |
| brk_swi | output | 1 | Pulse: main-CPU break as software interrupt |
| bank_oh | output | 4 | One-hot visible comparator bank |

## Verification
The assertions assume that `trace_done` and `final_reached` are single-cycle events raised by the external sequencer and trace logic. They also assume that `secure` and `trace_started` are held steady around a trigger write. The stimulus sets each of these inputs at a falling edge and keeps it for exactly one rising edge. It never raises a completion event in the same cycle as a write, so the hardware-clear priority only arises when a scenario tests it on purpose.

// File: rtl/dbg_arm_pkg.sv
package dbg_arm_pkg;
  localparam int REG_W    = 8;
  localparam int B_ARM    = 0;
  localparam int B_TRIG   = 1;
  localparam int B_SWBRK  = 2;
  localparam int B_MODE   = 3;
  localparam int B_TGT_LO = 4;
  localparam int B_BANK_LO = 6;

  typedef struct packed {
    logic [1:0] bank;
    logic [1:0] tgt;
    logic       mode;
    logic       swbrk_en;
  } dbg_fields_t;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_CP   = 2'b01,
    TGT_CPU  = 2'b10,
    TGT_BOTH = 2'b11
  } dbg_tgt_e;
endpackage

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
  import dbg_arm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             secure,
  input  logic             trace_started,
  input  logic             hw_disarm,
  output logic             arm,
  output dbg_fields_t      fields,
  output logic             enter_first,
  output logic             force_final
);
  dbg_fields_t wr_fields;
  logic        trig_ok;

  always_comb begin
    wr_fields.swbrk_en = wr_data[B_SWBRK];
    wr_fields.mode     = wr_data[B_MODE];
    wr_fields.tgt      = wr_data[B_TGT_LO +: 2];
    wr_fields.bank     = wr_data[B_BANK_LO +: 2];
    trig_ok = wr_en && arm && wr_data[B_ARM] && wr_data[B_TRIG]
              && !secure && !trace_started && !hw_disarm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm         <= 1'b0;
      fields      <= '0;
      enter_first <= 1'b0;
      force_final <= 1'b0;
    end else begin
      enter_first <= wr_en && !arm && wr_data[B_ARM];
      force_final <= trig_ok;
      if (hw_disarm)
        arm <= 1'b0;
      else if (wr_en)
        arm <= wr_data[B_ARM];
      if (wr_en && !arm)
        fields <= wr_fields;
    end
  end
endmodule

// File: rtl/dbg_brk_gen.sv
module dbg_brk_gen
  import dbg_arm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        arm,
  input  dbg_fields_t fields,
  input  logic        trace_en,
  input  logic        trace_done,
  input  logic        final_reached,
  input  logic        cp_swbrk_req,
  input  logic        bgnd_en,
  output logic        hw_disarm,
  output logic        cp_brk,
  output logic        brk_bgnd,
  output logic        brk_swi
);
  logic sess_end;
  logic cpu_fire;
  logic cp_fire;

  always_comb begin
    sess_end  = arm && (trace_en ? trace_done : final_reached);
    cp_fire   = sess_end && fields.tgt[0];
    cpu_fire  = (sess_end && fields.tgt[1]) || (cp_swbrk_req && fields.swbrk_en);
    hw_disarm = arm && ((trace_en && trace_done) ||
                        (!trace_en && final_reached && (fields.tgt != TGT_NONE)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_brk   <= 1'b0;
      brk_bgnd <= 1'b0;
      brk_swi  <= 1'b0;
    end else begin
      cp_brk   <= cp_fire;
      brk_bgnd <= cpu_fire && fields.mode && bgnd_en;
      brk_swi  <= cpu_fire && !bgnd_en;
    end
  end
endmodule

// File: rtl/dbg_bank_dec.sv
module dbg_bank_dec #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] bank_oh
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_dec
    assign bank_oh[g] = (bank == BANK_W'(g));
  end
endmodule

// File: rtl/dbg_arm_ctrl.sv
module dbg_arm_ctrl
  import dbg_arm_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             trace_en,
  input  logic             trace_started,
  input  logic             trace_done,
  input  logic             final_reached,
  input  logic             secure,
  input  logic             bgnd_en,
  input  logic             cp_swbrk_req,
  output logic             seq_enter_first,
  output logic             seq_force_final,
  output logic             cp_brk,
  output logic             brk_bgnd,
  output logic             brk_swi,
  output logic [NUM_BANKS-1:0] bank_oh
);
  logic        arm;
  logic        hw_disarm;
  dbg_fields_t fields;

  dbg_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .secure(secure), .trace_started(trace_started), .hw_disarm(hw_disarm),
    .arm(arm), .fields(fields),
    .enter_first(seq_enter_first), .force_final(seq_force_final)
  );

  dbg_brk_gen u_brk (
    .clk(clk), .rst(rst), .arm(arm), .fields(fields),
    .trace_en(trace_en), .trace_done(trace_done), .final_reached(final_reached),
    .cp_swbrk_req(cp_swbrk_req), .bgnd_en(bgnd_en),
    .hw_disarm(hw_disarm), .cp_brk(cp_brk), .brk_bgnd(brk_bgnd), .brk_swi(brk_swi)
  );

  dbg_bank_dec #(.NUM_BANKS(NUM_BANKS)) u_bank (
    .bank(fields.bank[((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0]),
    .bank_oh(bank_oh)
  );

  always_comb begin
    rd_data                  = '0;
    rd_data[B_ARM]           = arm;
    rd_data[B_SWBRK]         = fields.swbrk_en;
    rd_data[B_MODE]          = fields.mode;
    rd_data[B_TGT_LO +: 2]   = fields.tgt;
    rd_data[B_BANK_LO +: 2]  = fields.bank;
  end
endmodule

// File: rtl/dbg_arm_ctrl_chk.sv
module dbg_arm_ctrl_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       secure,
  input logic       trace_started,
  input logic       seq_enter_first,
  input logic       seq_force_final,
  input logic       cp_brk,
  input logic       brk_bgnd,
  input logic       brk_swi,
  input logic [NUM_BANKS-1:0] bank_oh
);
  p_lock_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_data[0] && wr_en) |=> $stable(rd_data[7:2]));

  p_trig_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_data[1]);

  p_enter_first_r2: assert property (@(posedge clk) disable iff (rst)
    seq_enter_first |-> (rd_data[0] && !$past(rd_data[0])));

  p_trig_blocked_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (secure || trace_started)) |=> !seq_force_final);

  p_route_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(brk_bgnd && brk_swi));

  p_cp_target_r6: assert property (@(posedge clk) disable iff (rst)
    cp_brk |-> $past(rd_data[4]));

  p_bank_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_oh) && (bank_oh != '0));
endmodule

bind dbg_arm_ctrl dbg_arm_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .secure(secure), .trace_started(trace_started),
  .seq_enter_first(seq_enter_first), .seq_force_final(seq_force_final),
  .cp_brk(cp_brk), .brk_bgnd(brk_bgnd), .brk_swi(brk_swi), .bank_oh(bank_oh)
);

// File: tb/test_dbg_arm_ctrl.sv
module test_dbg_arm_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic trace_en = 0, trace_started = 0, trace_done = 0, final_reached = 0;
  logic secure = 0, bgnd_en = 0, cp_swbrk_req = 0;
  logic seq_enter_first, seq_force_final, cp_brk, brk_bgnd, brk_swi;
  logic [3:0] bank_oh;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_arm_ctrl i_dbg_arm_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .trace_en(trace_en), .trace_started(trace_started), .trace_done(trace_done),
    .final_reached(final_reached), .secure(secure), .bgnd_en(bgnd_en),
    .cp_swbrk_req(cp_swbrk_req), .seq_enter_first(seq_enter_first),
    .seq_force_final(seq_force_final), .cp_brk(cp_brk), .brk_bgnd(brk_bgnd),
    .brk_swi(brk_swi), .bank_oh(bank_oh)
  );

  // {write data, expected readback} for writes while disarmed
  localparam logic [15:0] VEC [6] = '{16'hFE_FC, 16'h54_54, 16'hA8_A8,
                                      16'h02_00, 16'h3C_3C, 16'hC0_C0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs already set after a falling edge; pass one rising edge, clear strobes
  task automatic step();
    @(negedge clk);
    wr_en = 0; trace_done = 0; final_reached = 0; cp_swbrk_req = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    step();
  endtask

  function automatic logic [2:0] brk3();
    return {cp_brk, brk_bgnd, brk_swi};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check(rd_data == 8'h00, "R10 reset word", rd_data, 0);
    check(bank_oh == 4'b0001, "R10 reset bank", bank_oh, 1);
    check({seq_enter_first, seq_force_final, brk3()} == 0, "R10 reset pulses",
          {seq_enter_first, seq_force_final, brk3()}, 0);

    // table of disarmed writes: R1 layout, R4 trig reads 0, R10 bank decode
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][15:8]);
      check(rd_data == VEC[i][7:0], "R1 readback", rd_data, VEC[i][7:0]);
      check(bank_oh == (4'b1 << VEC[i][15:14]), "R10 bank", bank_oh, 4'b1 << VEC[i][15:14]);
    end

    // R1/R2 arm
    wr(8'h30);
    wr(8'h31);
    check(rd_data == 8'h31, "R1 arm set", rd_data, 8'h31);
    check(seq_enter_first == 1, "R2 enter first", seq_enter_first, 1);
    // R3 lock
    wr(8'hCD);
    check(rd_data == 8'h31, "R3 locked", rd_data, 8'h31);
    check(seq_enter_first == 0, "R2 no re-entry while armed", seq_enter_first, 0);
    // R4 trigger
    wr(8'h33);
    check(seq_force_final == 1, "R4 trigger", seq_force_final, 1);
    check(rd_data == 8'h31, "R4 trig reads 0", rd_data, 8'h31);
    wr(8'h31);
    check(seq_force_final == 0, "R4 zero write", seq_force_final, 0);
    // R5
    secure = 1; wr(8'h33); secure = 0;
    check(seq_force_final == 0, "R5 secure", seq_force_final, 0);
    trace_started = 1; wr(8'h33); trace_started = 0;
    check(seq_force_final == 0, "R5 trace started", seq_force_final, 0);

    // R6/R7 no tracing: break on final state, arm clears
    final_reached = 1; step();
    check(brk3() == 3'b101, "R6 both targets", brk3(), 3'b101);
    check(rd_data == 8'h30, "R1 hw disarm no-trace", rd_data, 8'h30);

    // R7 tracing: final gives nothing, trace_done gives break
    wr(8'h31);
    trace_en = 1; final_reached = 1; step();
    check(brk3() == 0, "R7 final ignored when tracing", brk3(), 0);
    check(rd_data == 8'h31, "R7 still armed", rd_data, 8'h31);
    trace_done = 1; step();
    check(brk3() == 3'b101, "R7 break at trace end", brk3(), 3'b101);
    check(rd_data == 8'h30, "R1 hw disarm trace", rd_data, 8'h30);
    trace_en = 0;

    // R6 target 01 only coprocessor
    wr(8'h10); wr(8'h11);
    final_reached = 1; step();
    check(brk3() == 3'b100, "R6 target 01", brk3(), 3'b100);

    // R6/R1 target 00: no break, stays armed; software disarm
    wr(8'h00); wr(8'h01);
    final_reached = 1; step();
    check(brk3() == 0, "R6 target 00", brk3(), 0);
    check(rd_data == 8'h01, "R1 stays armed", rd_data, 8'h01);
    wr(8'h00);
    check(rd_data == 8'h00, "R1 sw disarm", rd_data, 0);

    // R1 hw clear beats a write in the same cycle
    wr(8'h20); wr(8'h21);
    final_reached = 1; wr_en = 1; wr_data = 8'h21; step();
    check(rd_data == 8'h20, "R1 hw clear priority", rd_data, 8'h20);

    // R8 coprocessor software break
    wr(8'h04);
    cp_swbrk_req = 1; step();
    check(brk3() == 3'b001, "R8 passed", brk3(), 3'b001);
    wr(8'h00);
    cp_swbrk_req = 1; step();
    check(brk3() == 0, "R8 blocked", brk3(), 0);

    // R9 routing
    bgnd_en = 1; wr(8'h0C);
    cp_swbrk_req = 1; step();
    check(brk3() == 3'b010, "R9 to background", brk3(), 3'b010);
    wr(8'h04);
    cp_swbrk_req = 1; step();
    check(brk3() == 0, "R9 dropped", brk3(), 0);
    bgnd_en = 0; wr(8'h0C);
    cp_swbrk_req = 1; step();
    check(brk3() == 3'b001, "R9 swi fallback", brk3(), 3'b001);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule